// File: doc/BRIEF.md
# Frame-Start Rate Measurement Counter

This block measures how many frame-start pulses arrive while a programmable number of frame-synchronization ticks goes by. Both pulse inputs may be asynchronous to the block clock. Each passes through a two-flop synchronizer and a rising-edge detector. A window counter tallies sync edges, and an accumulator tallies start edges. When the window counter reaches the programmed reference, the accumulator is copied into the result register.

In continuous mode, one window follows the next with no gap. In halt mode, counting stops after each capture and resumes only after the host reads the result. An optional active-low interrupt marks each capture. It stays low until the result is read or the block is taken out of run.

Top module: `frame_rate_meter`

## Requirements
- R1: After reset, `result` is 0 and `irq_n` is 1.
- R2: While `ref_count` is 0, no window completes. `result` is unchanged and no interrupt is raised.
- R3: When `ref_count` = N (N > 0), a window ends on the N-th synchronized rising edge of `fsync_in` counted from its start. At that point `result` takes the number of synchronized rising edges of `fstart_in` seen during the window.
- R4: With `cont_mode` = 1, every completed window reloads `result`, and the next window starts at once with no lost edges.
- R5: With `cont_mode` = 0, counting stops after a capture. Edges that arrive while stopped are ignored and `result` holds. A one-cycle `rd_strobe` starts a fresh window, counted from zero.
- R6: With `irq_en` = 1, `irq_n` goes low on each capture. With `irq_en` = 0, a capture never drives `irq_n` low.
- R7: Once low, `irq_n` stays low until `rd_strobe` is seen or `run` is 0. Either event returns it to 1.
- R8: With `run` = 0, the window counter and the start-edge accumulator are cleared. The last captured `result` is kept.
- R9: In continuous mode, a start edge detected in the same cycle that the window completes is counted in the following window.
- R10: The start-edge accumulator saturates at all ones (2^W − 1) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables counting; 0 clears the counters and the interrupt |
| cont_mode | input | 1 | 1 = continuous windows, 0 = halt after each capture until read |
| irq_en | input | 1 | Enables the interrupt on capture |
| ref_count | input | W | Window length in frame-sync ticks; 0 disables counting |
| rd_strobe | input | 1 | One-cycle pulse marking a host read of the result |
| fstart_in | input | 1 | Frame-start pulse input (asynchronous) |
| fsync_in | input | 1 | Frame-sync tick input (asynchronous) |
| result | output | W | Start-edge count of the last completed window |
| irq_n | output | 1 | Active-low, level-held capture interrupt |

## Verification
The counting function is driven with windows that hold several start pulses, windows with none, and consecutive windows of different counts. These tell correct window length and capture apart from an off-by-one on the sync count or a missing reload. One pattern raises a start pulse together with the closing sync tick. It separates counting that edge in the next window from dropping it or adding it to the closing window. Further patterns send edges while halted, while `run` is low in mid-window, and with a zero reference. A run of more start pulses than a narrow accumulator can hold shows saturation rather than wrap.

// File: rtl/frame_rate_meter.sv
module frame_rate_meter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cont_mode,
  input  logic         irq_en,
  input  logic [W-1:0] ref_count,
  input  logic         rd_strobe,
  input  logic         fstart_in,
  input  logic         fsync_in,
  output logic [W-1:0] result,
  output logic         irq_n
);

  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [2:0]   st_sh, sy_sh;
  logic [W-1:0] win_cnt, acc;
  logic         halted;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_sh <= '0;
      sy_sh <= '0;
    end else begin
      st_sh <= {st_sh[1:0], fstart_in};
      sy_sh <= {sy_sh[1:0], fsync_in};
    end

  wire st_edge  = st_sh[1] & ~st_sh[2];
  wire sy_edge  = sy_sh[1] & ~sy_sh[2];
  wire enabled  = run && (ref_count != '0) && !halted;
  wire win_done = enabled && sy_edge && (win_cnt >= ref_count - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0;
      acc     <= '0;
      halted  <= 1'b0;
      result  <= '0;
      irq_n   <= 1'b1;
    end else if (!run) begin
      win_cnt <= '0;
      acc     <= '0;
      halted  <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      if (rd_strobe) begin
        irq_n  <= 1'b1;
        halted <= 1'b0;
      end
      if (win_done) begin
        result  <= acc;
        win_cnt <= '0;
        acc     <= (cont_mode && st_edge) ? {{(W-1){1'b0}}, 1'b1} : '0;
        if (!cont_mode) halted <= 1'b1;
        if (irq_en)     irq_n  <= 1'b0;
      end else if (enabled) begin
        if (sy_edge)                 win_cnt <= win_cnt + 1'b1;
        if (st_edge && acc != ALL1)  acc     <= acc + 1'b1;
      end
    end

  a_r2_ref_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_count == '0) |=> $stable(result));

  a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !rd_strobe) |=> ($stable(result) && acc == '0));

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(irq_en));

  a_r7_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || (rd_strobe && !win_done)) |=> irq_n);

  a_r8_stop_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(result) && acc == '0 && win_cnt == '0));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ALL1 && run && !win_done) |=> acc == ALL1);

endmodule

// File: tb/frame_rate_meter_bench.sv
module frame_rate_meter_bench;
  logic clk = 0, rst_n = 0;
  logic run = 0, cont_mode = 0, irq_en = 0, rd_strobe = 0;
  logic fstart_in = 0, fsync_in = 0;
  logic [15:0] ref_count = 0, result;
  logic [3:0]  result_n;
  logic irq_n, irq_n_n;
  int checks = 0, fails = 0;
  int expq[$];
  bit mon_on = 0, auto_ack = 0;

  always #5 clk = ~clk;

  frame_rate_meter #(.W(16)) u_frame_rate_meter (
    .clk(clk), .rst_n(rst_n), .run(run), .cont_mode(cont_mode), .irq_en(irq_en),
    .ref_count(ref_count), .rd_strobe(rd_strobe), .fstart_in(fstart_in),
    .fsync_in(fsync_in), .result(result), .irq_n(irq_n));

  frame_rate_meter #(.W(4)) u_frame_rate_meter_narrow (
    .clk(clk), .rst_n(rst_n), .run(run), .cont_mode(cont_mode), .irq_en(irq_en),
    .ref_count(ref_count[3:0]), .rd_strobe(1'b0), .fstart_in(fstart_in),
    .fsync_in(fsync_in), .result(result_n), .irq_n(irq_n_n));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic pulse(bit s, bit y);
    @(negedge clk); fstart_in = s; fsync_in = y;
    repeat (2) @(negedge clk);
    fstart_in = 0; fsync_in = 0;
    @(negedge clk);
  endtask

  task automatic starts(int n);
    for (int i = 0; i < n; i++) pulse(1, 0);
  endtask

  task automatic syncs(int n);
    for (int i = 0; i < n; i++) pulse(0, 1);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic read();
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
  endtask

  // monitor: each falling irq_n pops one expected result
  initial begin
    bit prev = 1;
    forever begin
      @(negedge clk);
      if (mon_on && prev && !irq_n) begin
        if (expq.size() == 0) chk("R4 unexpected capture", int'(result), -1);
        else chk("R3/R4 window result", int'(result), expq.pop_front());
        if (auto_ack) begin
          rd_strobe = 1;
          @(negedge clk); rd_strobe = 0;
          chk("R7 irq released by read", int'(irq_n), 1);
        end
      end
      prev = irq_n;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset irq_n", int'(irq_n), 1);
    rst_n = 1;

    // continuous windows, ref = 3
    ref_count = 3; cont_mode = 1; irq_en = 1; run = 1;
    mon_on = 1; auto_ack = 1;
    expq.push_back(5); starts(5); syncs(3);
    expq.push_back(0); syncs(3);
    expq.push_back(2); starts(1); syncs(1); starts(1); syncs(2);
    // R9: start coincident with closing sync goes to the next window
    expq.push_back(3); starts(3); syncs(2); pulse(1, 1);
    expq.push_back(3); starts(2); syncs(3);
    settle();
    chk("R4 all continuous windows seen", expq.size(), 0);
    mon_on = 0; auto_ack = 0;

    // halt mode, manual read, ref = 2
    run = 0; @(negedge clk); run = 1; cont_mode = 0; ref_count = 2;
    starts(4); syncs(2); settle();
    chk("R3 halt capture", int'(result), 4);
    chk("R6 irq low on capture", int'(irq_n), 0);
    starts(3); syncs(2); settle();
    chk("R5 halted result holds", int'(result), 4);
    chk("R7 irq held low", int'(irq_n), 0);
    read(); @(negedge clk);
    chk("R7 irq high after read", int'(irq_n), 1);
    starts(1); syncs(2); settle();
    chk("R5 fresh window after read", int'(result), 1);
    read();

    // interrupt disabled
    irq_en = 0;
    starts(2); syncs(2); settle();
    chk("R6 result with irq off", int'(result), 2);
    chk("R6 no irq when disabled", int'(irq_n), 1);
    read();

    // run clear
    irq_en = 1;
    starts(3); syncs(2); settle();
    chk("R3 capture before stop", int'(result), 3);
    run = 0; repeat (2) @(negedge clk);
    chk("R7 irq high on run low", int'(irq_n), 1);
    chk("R8 result kept on run low", int'(result), 3);
    run = 1; cont_mode = 1;
    starts(1); syncs(1); settle();
    run = 0; @(negedge clk); run = 1;
    starts(2); syncs(2); settle();
    chk("R8 accumulator cleared by run low", int'(result), 2);
    read();

    // zero reference
    ref_count = 0;
    starts(4); syncs(5); settle();
    chk("R2 result unchanged with zero ref", int'(result), 2);
    chk("R2 no irq with zero ref", int'(irq_n), 1);

    // saturation on narrow instance
    run = 0; @(negedge clk); run = 1; irq_en = 0; ref_count = 1;
    starts(20); syncs(1); settle();
    chk("R3 twenty edges counted", int'(result), 20);
    chk("R10 narrow accumulator saturates", int'(result_n), 15);

    summary();
  end
endmodule